// File: doc/BRIEF.md
# Time-Shared Multi-Finger Despreader

This block despreads a stream of complex baseband samples for sixteen rake fingers with a single datapath. Each accepted input sample is offered in turn to every finger, one finger per clock, by a slot counter. That counter also addresses small per-finger memories. The memories hold each finger's running I/Q sum, its chip count and its configuration: enable, sample phase, spreading-factor code and channel tag. The code chips for the finger being served come from an external code source. The block drives a slot index out to that source, and the source returns three binary chips in the same cycle.

Input samples arrive at twice the chip rate. Each finger takes only the samples whose phase matches its configured phase bit, so it sees one sample per chip. Each chip multiplies the sample by the conjugate of a ±1 complex code, and the block does this with negations and additions only. When a finger has summed as many chips as its spreading factor, the block presents the despread symbol on a valid/ready output, tagged with the finger and channel numbers, and clears that finger's sum. Back-pressure on the output freezes the sweep, so no symbol is lost. While the sweep is frozen, or while a sample is in progress, the input shows not-ready.

Top module: `tsdespread_engine`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, every finger is disabled, and every running sum and chip count is zero. The first accepted sample has phase 0.
- R2: A sample is taken on a clock edge where in_valid and in_ready are both 1. in_ready is then 0 until all 16 fingers have been served. The sample phase alternates 0,1,0,1 over accepted samples.
- R3: A code chip value of 0 means +1 and 1 means -1. The effective code has a = spread xor scr_i and b = spread xor scr_q. Each chip adds I·a + Q·b to the I sum and Q·a − I·b to the Q sum.
- R4: A finger takes a chip from a sample only if its enable bit is 1 and its phase bit equals the sample's phase. A disabled finger never produces an output.
- R5: The spreading factor is 4 shifted left by the 3-bit sf code, for codes 0 to 6 (4 to 256); code 7 also means 256. On the chip that completes the spreading factor, the sum including that chip is emitted, and the finger's sum and count are cleared.
- R6: Each sum is 16-bit signed and saturates at +32767 and −32768 instead of wrapping.
- R7: Symbols from one sample appear in ascending finger order. Each symbol carries its finger index and the finger's 4-bit channel tag (0 to 15).
- R8: While out_valid is 1 and out_ready is 0, the output data stay unchanged and the sweep pauses. A symbol leaves only on out_valid and out_ready both 1.
- R9: A configuration write (cfg_we) loads enable, phase, sf code and channel for cfg_finger, and clears that finger's sum and count.
- R10: code_slot shows the finger being served in the current cycle. The three code chip inputs are used in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_i | input | 8 | Sample in-phase, signed |
| in_q | input | 8 | Sample quadrature, signed |
| code_slot | output | 4 | Finger whose code chips are wanted this cycle |
| code_spread | input | 1 | Spreading chip (0 = +1, 1 = −1) |
| code_scr_i | input | 1 | Scrambling chip, real part |
| code_scr_q | input | 1 | Scrambling chip, imaginary part |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_finger | input | 4 | Finger written |
| cfg_enable | input | 1 | Finger enable |
| cfg_phase | input | 1 | Sample phase the finger takes |
| cfg_sf_code | input | 3 | Spreading factor code |
| cfg_chan | input | 4 | Channel tag |
| out_valid | output | 1 | Symbol valid |
| out_ready | input | 1 | Receiver takes the symbol |
| out_finger | output | 4 | Finger index of the symbol |
| out_chan | output | 4 | Channel tag of the symbol |
| out_i | output | 16 | Symbol in-phase, signed |
| out_q | output | 16 | Symbol quadrature, signed |

## Verification
A corrupted running sum, or one left uncleared, shows as a wrong out_i or out_q on that finger's next symbol. That symbol can be as little as four chips later, or as much as 256 chips (512 samples) later for the longest spreading factor. A chip count, phase or slot-order fault shows as a symbol from the wrong finger, or one that arrives early, late, extra or missing. The bench keeps an arithmetic model of every finger and matches each output symbol, in order, against the model's queue, so the first such symbol is caught. Saturation is driven to both limits with constant full-scale samples, and the output is stalled at random to exercise back-pressure.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int FINGERS    = 16;
  localparam int FID_W      = $clog2(FINGERS);
  localparam int SAMP_W     = 8;
  localparam int ACC_W      = 16;
  localparam int SFC_W      = 3;
  localparam int SFC_MAX    = 6;               // code giving the largest spreading factor
  localparam int CNT_W      = SFC_MAX + 2;     // chip count up to 4<<SFC_MAX - 1
  localparam int CHAN_W     = 4;

  typedef struct packed {
    logic              en;
    logic              phase;
    logic [SFC_W-1:0]  sf_code;
    logic [CHAN_W-1:0] chan;
  } fparam_t;
endpackage

// File: rtl/dsr_param_bank.sv
module dsr_param_bank
  import dsr_pkg::*;
#(
  parameter int N = FINGERS,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  fparam_t       wr_data,
  input  logic [IW-1:0] rd_idx,
  output fparam_t       rd_data
);
  fparam_t mem [N];

  for (genvar k = 0; k < N; k++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[k] <= '0;
      else if (wr_en && wr_idx == IW'(k))
        mem[k] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/dsr_slot_seq.sv
module dsr_slot_seq
  import dsr_pkg::*;
#(
  parameter int N = FINGERS,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          adv,
  output logic          busy,
  output logic [IW-1:0] slot,
  output logic          samp_phase
);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic take;
  assign in_ready = !busy;
  assign take     = in_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      slot       <= '0;
      samp_phase <= 1'b1;   // first accepted sample flips this to 0
    end else if (take) begin
      busy       <= 1'b1;
      slot       <= '0;
      samp_phase <= ~samp_phase;
    end else if (busy && adv) begin
      if (slot == LAST) begin
        busy <= 1'b0;
        slot <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end

  // R2: an accepted sample closes the input for the following cycle
  assert_take_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R10: the served finger steps by one per advancing cycle
  assert_slot_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && adv && slot != LAST) |=> (busy && slot == IW'($past(slot) + 1'b1)));

  // R8: output back-pressure freezes the sweep
  assert_stall_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adv) |=> (busy && $stable(slot)));
endmodule

// File: rtl/dsr_chip_mac.sv
module dsr_chip_mac
  import dsr_pkg::*;
#(
  parameter int SW = SAMP_W,
  parameter int AW = ACC_W
) (
  input  logic [SW-1:0] smp_i,
  input  logic [SW-1:0] smp_q,
  input  logic          c_spread,
  input  logic          c_scr_i,
  input  logic          c_scr_q,
  input  logic [AW-1:0] acc_i,
  input  logic [AW-1:0] acc_q,
  output logic [AW-1:0] sum_i,
  output logic [AW-1:0] sum_q
);
  localparam int TW = SW + 2;

  logic neg_a, neg_b;
  logic signed [TW-1:0] ie, qe, ia, ib, qa, qb, term_i, term_q;

  assign neg_a = c_spread ^ c_scr_i;
  assign neg_b = c_spread ^ c_scr_q;
  assign ie    = {{2{smp_i[SW-1]}}, smp_i};
  assign qe    = {{2{smp_q[SW-1]}}, smp_q};
  assign ia    = neg_a ? -ie : ie;
  assign qa    = neg_a ? -qe : qe;
  assign ib    = neg_b ? -ie : ie;
  assign qb    = neg_b ? -qe : qe;
  assign term_i = ia + qb;
  assign term_q = qa - ib;

  function automatic logic [AW-1:0] sat_add(input logic [AW-1:0] a, input logic [TW-1:0] t);
    logic [AW:0] s;
    s = {a[AW-1], a} + {{(AW + 1 - TW){t[TW-1]}}, t};
    if (s[AW] != s[AW-1])
      return s[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
    return s[AW-1:0];
  endfunction

  assign sum_i = sat_add(acc_i, term_i);
  assign sum_q = sat_add(acc_q, term_q);
endmodule

// File: rtl/tsdespread_engine.sv
module tsdespread_engine
  import dsr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMP_W-1:0]   in_i,
  input  logic [SAMP_W-1:0]   in_q,
  output logic [FID_W-1:0]    code_slot,
  input  logic                code_spread,
  input  logic                code_scr_i,
  input  logic                code_scr_q,
  input  logic                cfg_we,
  input  logic [FID_W-1:0]    cfg_finger,
  input  logic                cfg_enable,
  input  logic                cfg_phase,
  input  logic [SFC_W-1:0]    cfg_sf_code,
  input  logic [CHAN_W-1:0]   cfg_chan,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [FID_W-1:0]    out_finger,
  output logic [CHAN_W-1:0]   out_chan,
  output logic [ACC_W-1:0]    out_i,
  output logic [ACC_W-1:0]    out_q
);
  // sample latch
  logic [SAMP_W-1:0] smp_i, smp_q;
  logic busy, adv, samp_phase, take;
  logic [FID_W-1:0] slot;

  assign adv  = !out_valid || out_ready;
  assign take = in_valid && in_ready;

  dsr_slot_seq #(.N(FINGERS)) u_seq (
    .clk, .rst_n, .in_valid, .in_ready, .adv, .busy, .slot, .samp_phase
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_i <= '0;
      smp_q <= '0;
    end else if (take) begin
      smp_i <= in_i;
      smp_q <= in_q;
    end
  end

  // per-finger parameters
  fparam_t wr_par, cur_par;
  assign wr_par = '{en: cfg_enable, phase: cfg_phase, sf_code: cfg_sf_code, chan: cfg_chan};

  dsr_param_bank #(.N(FINGERS)) u_par (
    .clk, .rst_n, .wr_en(cfg_we), .wr_idx(cfg_finger), .wr_data(wr_par),
    .rd_idx(slot), .rd_data(cur_par)
  );

  // per-finger running state
  logic [ACC_W-1:0] acc_i [FINGERS];
  logic [ACC_W-1:0] acc_q [FINGERS];
  logic [CNT_W-1:0] cnt   [FINGERS];

  logic [SFC_W-1:0] eff_code;
  logic [CNT_W:0]   sf_full;
  logic [CNT_W-1:0] sf_m1, cnt_cur;
  logic             act, last;
  logic [ACC_W-1:0] sum_i, sum_q;

  assign eff_code = (cur_par.sf_code > SFC_W'(SFC_MAX)) ? SFC_W'(SFC_MAX) : cur_par.sf_code;
  assign sf_full  = (CNT_W + 1)'(4) << eff_code;
  assign sf_m1    = CNT_W'(sf_full - 1'b1);
  assign cnt_cur  = cnt[slot];
  assign act      = busy && adv && cur_par.en && (cur_par.phase == samp_phase);
  assign last     = (cnt_cur == sf_m1);
  assign code_slot = slot;

  dsr_chip_mac #(.SW(SAMP_W), .AW(ACC_W)) u_mac (
    .smp_i, .smp_q,
    .c_spread(code_spread), .c_scr_i(code_scr_i), .c_scr_q(code_scr_q),
    .acc_i(acc_i[slot]), .acc_q(acc_q[slot]),
    .sum_i, .sum_q
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < FINGERS; k++) begin
        acc_i[k] <= '0;
        acc_q[k] <= '0;
        cnt[k]   <= '0;
      end
    end else begin
      for (int k = 0; k < FINGERS; k++) begin
        if (cfg_we && cfg_finger == FID_W'(k)) begin
          acc_i[k] <= '0;
          acc_q[k] <= '0;
          cnt[k]   <= '0;
        end else if (act && slot == FID_W'(k)) begin
          if (last) begin
            acc_i[k] <= '0;
            acc_q[k] <= '0;
            cnt[k]   <= '0;
          end else begin
            acc_i[k] <= sum_i;
            acc_q[k] <= sum_q;
            cnt[k]   <= cnt[k] + 1'b1;
          end
        end
      end
    end
  end

  // output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_finger <= '0;
      out_chan   <= '0;
      out_i      <= '0;
      out_q      <= '0;
    end else if (act && last) begin
      out_valid  <= 1'b1;
      out_finger <= slot;
      out_chan   <= cur_par.chan;
      out_i      <= sum_i;
      out_q      <= sum_q;
    end else if (out_valid && out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  // R8: a stalled symbol stays put
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)
                                   && $stable(out_finger) && $stable(out_chan)));

  // R5: a served finger's chip count never passes its spreading factor
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (cnt_cur <= sf_m1));
endmodule

// File: tb/test_tsdespread_engine.sv
module test_tsdespread_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic in_valid = 1'b0, in_ready;
  logic [7:0] in_i = '0, in_q = '0;
  logic [3:0] code_slot;
  logic code_spread, code_scr_i, code_scr_q;
  logic cfg_we = 1'b0, cfg_enable = 1'b0, cfg_phase = 1'b0;
  logic [3:0] cfg_finger = '0, cfg_chan = '0;
  logic [2:0] cfg_sf_code = '0;
  logic out_valid, out_ready = 1'b0;
  logic [3:0] out_finger, out_chan;
  logic [15:0] out_i, out_q;

  tsdespread_engine i_tsdespread_engine (
    .clk, .rst_n, .in_valid, .in_ready, .in_i, .in_q, .code_slot,
    .code_spread, .code_scr_i, .code_scr_q,
    .cfg_we, .cfg_finger, .cfg_enable, .cfg_phase, .cfg_sf_code, .cfg_chan,
    .out_valid, .out_ready, .out_finger, .out_chan, .out_i, .out_q
  );

  int nchk = 0, nfail = 0;
  bit done = 0, started = 0, force_ready = 0, sat_mode = 0;
  int cur_idx = 0, nsent = 0, mphase = 0, nout = 0, cyc = 0;
  logic [31:0] rng = 32'h1234_5678;

  // model of each finger
  bit m_en[16], m_ph[16];
  int m_sf[16], m_ch[16], m_ai[16], m_aq[16], m_cnt[16];
  int q_f[$], q_c[$], q_i[$], q_q[$];
  int last_i = 0, last_q = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] codefn(int slot, int idx);
    int v;
    if (sat_mode) return 3'b000;
    v = slot * 29 + idx * 13 + (idx >> 3) * 7;
    return {1'(v ^ (v >> 4)), 1'((v >> 1) ^ (v >> 5)), 1'((v >> 2) ^ idx)};
  endfunction

  // R10: code chips answer the slot the block presents
  always_comb {code_spread, code_scr_i, code_scr_q} = codefn(int'(code_slot), cur_idx);

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // R3/R4/R5/R6 reference arithmetic for one accepted sample
  task automatic model_step(int si, int sq);
    for (int f = 0; f < 16; f++) begin
      if (m_en[f] && int'(m_ph[f]) == mphase) begin
        logic [2:0] c;
        int a, b;
        c = codefn(f, cur_idx);
        a = (c[2] ^ c[1]) ? -1 : 1;
        b = (c[2] ^ c[0]) ? -1 : 1;
        m_ai[f] = sat16(m_ai[f] + si * a + sq * b);
        m_aq[f] = sat16(m_aq[f] + sq * a - si * b);
        m_cnt[f]++;
        if (m_cnt[f] == m_sf[f]) begin
          q_f.push_back(f); q_c.push_back(m_ch[f]);
          q_i.push_back(m_ai[f]); q_q.push_back(m_aq[f]);
          m_ai[f] = 0; m_aq[f] = 0; m_cnt[f] = 0;
        end
      end
    end
    mphase ^= 1;
  endtask

  task automatic cfg(int f, bit en, bit ph, int code, int ch);
    while (!in_ready || in_valid) @(negedge clk);
    cfg_we = 1; cfg_finger = 4'(f); cfg_enable = en; cfg_phase = ph;
    cfg_sf_code = 3'(code); cfg_chan = 4'(ch);
    m_en[f] = en; m_ph[f] = ph; m_ch[f] = ch;
    m_sf[f] = 4 << ((code > 6) ? 6 : code);   // R5: code 7 -> 256
    m_ai[f] = 0; m_aq[f] = 0; m_cnt[f] = 0;     // R9: write clears
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(int si, int sq);
    in_i = 8'(si); in_q = 8'(sq); in_valid = 1;
    while (!in_ready) @(negedge clk);
    cur_idx = nsent;
    model_step(si, sq);
    @(negedge clk);
    in_valid = 0;
    chk(!in_ready, "R2 in_ready after accept", int'(in_ready), 0);
    nsent++;
  endtask

  task automatic drain();
    int t = 0;
    while ((q_f.size() != 0 || out_valid || !in_ready) && t < 5000) begin
      @(negedge clk); t++;
    end
    chk(q_f.size() == 0, "R4/R7 expected symbols outstanding", q_f.size(), 0);
  endtask

  // output monitor with random back-pressure
  bit hold = 0;
  int h_i, h_q, h_f;
  always @(negedge clk) begin
    if (rst_n && started) begin
      bit r;
      if (hold) begin
        chk(out_valid == 1, "R8 valid held", int'(out_valid), 1);
        chk(int'(out_i) == h_i && int'(out_q) == h_q && int'(out_finger) == h_f,
            "R8 stalled data stable", int'(out_i), h_i);
      end
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      r = force_ready ? 1'b1 : (rng[1:0] != 2'b00);
      out_ready = r;
      hold = out_valid && !r;
      h_i = int'(out_i); h_q = int'(out_q); h_f = int'(out_finger);
      if (out_valid && r) begin
        nout++;
        if (q_f.size() == 0) begin
          chk(0, "R4 unexpected symbol from finger", int'(out_finger), -1);
        end else begin
          chk(int'(out_finger) == q_f[0], "R7 finger order", int'(out_finger), q_f[0]);
          chk(int'(out_chan) == q_c[0], "R7 channel tag", int'(out_chan), q_c[0]);
          chk(int'($signed(out_i)) == q_i[0], "R3/R5/R6 symbol I", int'($signed(out_i)), q_i[0]);
          chk(int'($signed(out_q)) == q_q[0], "R3/R5/R6 symbol Q", int'($signed(out_q)), q_q[0]);
          void'(q_f.pop_front()); void'(q_c.pop_front());
          void'(q_i.pop_front()); void'(q_q.pop_front());
        end
        last_i = int'($signed(out_i)); last_q = int'($signed(out_q));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < 16; f++) begin
      m_en[f] = 0; m_ph[f] = 0; m_sf[f] = 4; m_ch[f] = 0;
      m_ai[f] = 0; m_aq[f] = 0; m_cnt[f] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1, "R1 in_ready after reset", int'(in_ready), 1);
    // R1/R4: all fingers disabled after reset -> no symbols
    started = 1;
    for (int n = 0; n < 40; n++) send(n * 3 - 60, 50 - n * 2);
    drain();
    chk(nout == 0, "R1/R4 output from unconfigured fingers", nout, 0);

    // main sweep: mixed spreading factors, phases, enables
    cfg(0, 1, 0, 0, 3);
    cfg(1, 1, 1, 1, 1);
    cfg(2, 0, 0, 0, 9);
    cfg(3, 1, 0, 7, 5);
    cfg(4, 1, 1, 2, 0);
    cfg(5, 1, 0, 6, 15);
    cfg(6, 1, 1, 3, 6);
    for (int k = 7; k < 16; k++) cfg(k, (k % 3) != 0, 1'(k & 1), k % 5, 15 - k);
    for (int n = 0; n < 1100; n++) begin
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      send(int'($signed(rng[7:0])), int'($signed(rng[15:8])));
    end
    drain();
    chk(nout > 300, "R5 symbol count in main sweep", nout, 300);

    // R9: rewrite fingers mid-symbol; sums restart
    for (int n = 0; n < 5; n++) send(100 - n * 40, n * 25 - 60);
    cfg(0, 1, 1, 1, 12);
    cfg(5, 1, 0, 0, 7);
    cfg(3, 0, 0, 7, 5);
    for (int n = 0; n < 60; n++) send(n * 4 - 120, 90 - n * 3);
    drain();

    // R6: saturation at both limits on a 256-chip finger
    for (int k = 1; k < 16; k++) cfg(k, 0, 0, 0, 0);
    cfg(0, 1, 0, 6, 2);
    sat_mode = 1; force_ready = 1;
    for (int n = 0; n < 512; n++) send(127, 127);
    drain();
    chk(last_i == 32767, "R6 positive saturation I", last_i, 32767);
    chk(last_q == 0, "R6 positive saturation Q", last_q, 0);
    for (int n = 0; n < 512; n++) send(-128, -128);
    drain();
    chk(last_i == -32768, "R6 negative saturation I", last_i, -32768);
    chk(last_q == 0, "R6 negative saturation Q", last_q, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule